// File: doc/BRIEF.md
# Drum-Timed Instruction Sequencer

This block is the control sequencer of a processor whose main store is a rotating drum. Words pass under the read heads one per word-time. A timing band reports which address is passing at that moment, and the sequencer compares that address with the address it is waiting for. When they are equal, it pulses a strobe so that the arriving word is taken either into the instruction register or into the operand path.

An instruction word carries a sign, a two-digit decimal operation code, a four-digit operand address and a four-digit continuation address. All addresses are binary-coded decimal.

Each instruction passes through the same phases:

- A fetch searches for the next instruction. It uses the operand field or the continuation field of the previous instruction, as a one-bit selector chooses.
- A copy loads the operation code into a nine-bit state register.
- An optional indexing step adds an index value to the operand address. The adder is decimal but banded: the carry from the hundreds weight-1 bit into the weight-2 bit is dropped, as is the carry out of the top digit, so an address wraps inside its 200-word band.
- An operand search waits for the operand address to come round.
- An execute wait lasts until the execute logic reports completion.

Top module: `drum_seq`

## Requirements
- R1: After a synchronous active-high reset, state is 0, phase is fetch (0), the selector is continuation (0), both strobes are low and the instruction register is zero, so the search address is 0000.
- R2: During fetch the search address is the continuation field when the selector is 0 and the operand field when it is 1. Outside fetch it is the operand field.
- R3: In fetch, a valid band address equal to the search address raises `ir_load_o` in that cycle. At the next edge the word is captured (bit 40 sign, bits 39:32 code, bits 31:16 operand address, bits 15:0 continuation), state becomes 1, the selector becomes 1 and the phase becomes copy (1).
- R4: One cycle after copy, state equals {sign, code}, with state bit 8 the sign, bits 7:4 the tens digit and bits 3:0 the units digit.
- R5: If the state sign bit or state bit 2 is set after copy, the phase goes to index (2). One cycle later the operand field holds the indexed address, state bits 8 and 2 are clear and the phase is operand search (3). Otherwise the phase goes straight to 3 and the operand field is unchanged.
- R6: The index sum works as follows. The address splits into a low part (address mod 200) and a high part (address div 200). The low part is the sum of the low parts mod 200. The high part is the sum of the high parts mod 50. Adding 0195 therefore acts as minus 5 within a band.
- R7: In operand search, a valid band address equal to the operand field sets state bit 0 and moves the phase to execute (4). `opnd_rd_o` is high in that cycle unless the code equals SKIP_CODE (26), which gets the same search and match but no strobe.
- R8: Neither strobe rises while `band_valid` is low, nor on a band address that does not match. The phase holds.
- R9: In execute, `done` returns state to 0 and the phase to fetch at the next edge. If `take_c` is high with it, the selector returns to 0; otherwise the selector keeps its value.
- R10: `done` has no effect outside the execute phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| band_valid | input | 1 | Timing-band address is valid this word-time |
| band_addr | input | 16 | Timing-band address, four BCD digits |
| word_in | input | 41 | Word passing the heads this word-time |
| index_val | input | 16 | Index register value, four BCD digits |
| done | input | 1 | Execute logic reports instruction complete |
| take_c | input | 1 | With done: next fetch uses the continuation field |
| state_o | output | 9 | State register (sign, tens, units) |
| phase_o | output | 3 | Sequencer phase: 0 fetch, 1 copy, 2 index, 3 operand search, 4 execute |
| mc_sel_o | output | 1 | Next-address selector: 1 operand field, 0 continuation |
| ir_load_o | output | 1 | Instruction-register load strobe |
| opnd_rd_o | output | 1 | Operand read strobe |
| search_addr_o | output | 16 | Address currently searched for |
| ir_sign_o | output | 1 | Instruction sign |
| ir_op_o | output | 8 | Instruction code, two BCD digits |
| ir_m_o | output | 16 | Operand address field |
| ir_c_o | output | 16 | Continuation address field |

## Verification
The assertions take for granted the following:
- The band address and the index value are legal BCD.
- `done` is pulsed by the execute logic only after an operand match.
- A new band address arrives with `band_valid` each word-time.

The stimulus keeps to these assumptions. It builds every address digit by digit in the range 0 to 9, it raises `done` outside execute only to show that it is ignored, and it presents the band address directly at the searched value or at a deliberate mismatch. The index vectors include the band edges, 0199 plus 1, 9999 plus 1 and 0003 plus 0195, alongside pseudo-random decimal pairs.

// File: rtl/drum_seq_pkg.sv
package drum_seq_pkg;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_COPY   = 3'd1,
    PH_INDEX  = 3'd2,
    PH_OPSRCH = 3'd3,
    PH_EXEC   = 3'd4
  } phase_t;

  // Plain decimal digit add: returns {carry_out, digit}
  function automatic logic [4:0] dec_digit_add(input logic [3:0] a, input logic [3:0] b,
                                               input logic cin);
    logic [4:0] s;
    s = {1'b0, a} + {1'b0, b} + {4'b0, cin};
    if (s > 5'd9) return {1'b1, 4'(s - 5'd10)};
    return s;
  endfunction

  // Banded digit add: the weight-1 bit never carries into the upper bits.
  // Upper bits (weights 2,4,8 as a count of twos) add modulo 5 with carry out.
  function automatic logic [4:0] band_digit_add(input logic [3:0] a, input logic [3:0] b,
                                                input logic cin);
    logic       low;
    logic [3:0] hi;
    low = a[0] ^ b[0] ^ cin;
    hi  = {1'b0, a[3:1]} + {1'b0, b[3:1]};
    if (hi >= 4'd5) return {1'b1, 3'(hi - 4'd5), low};
    return {1'b0, hi[2:0], low};
  endfunction

endpackage

// File: rtl/drum_addr_match.sv
module drum_addr_match #(
  parameter int DIGITS = 4
) (
  input  logic                  valid,
  input  logic [4*DIGITS-1:0]   band,
  input  logic [4*DIGITS-1:0]   target,
  output logic                  hit
);
  logic [DIGITS-1:0] digit_eq;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign digit_eq[g] = (band[4*g +: 4] == target[4*g +: 4]);
  end

  assign hit = valid & (&digit_eq);
endmodule

// File: rtl/drum_band_adder.sv
module drum_band_adder
  import drum_seq_pkg::*;
#(
  parameter int DIGITS   = 4,
  parameter int BAND_POS = 2
) (
  input  logic [4*DIGITS-1:0] addr,
  input  logic [4*DIGITS-1:0] incr,
  output logic [4*DIGITS-1:0] sum
);
  always_comb begin : p_add
    logic       carry;
    logic [4:0] r;
    carry = 1'b0;
    sum   = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (i == BAND_POS) r = band_digit_add(addr[4*i +: 4], incr[4*i +: 4], carry);
      else               r = dec_digit_add(addr[4*i +: 4], incr[4*i +: 4], carry);
      sum[4*i +: 4] = r[3:0];
      carry         = r[4];
    end
  end
endmodule

// File: rtl/drum_seq_ctrl.sv
module drum_seq_ctrl
  import drum_seq_pkg::*;
#(
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          band_hit,
  input  logic          done,
  input  logic          take_c,
  input  logic          need_read,
  input  logic [SW-1:0] op_word,
  output phase_t        phase,
  output logic [SW-1:0] state,
  output logic          mc_sel,
  output logic          ir_load,
  output logic          opnd_rd,
  output logic          m_update
);
  localparam int BIT_SIGN = SW - 1;
  localparam int BIT_FOUR = 2;

  logic want_index;

  assign want_index = op_word[BIT_SIGN] | op_word[BIT_FOUR];
  assign ir_load    = (phase == PH_FETCH)  && band_hit;
  assign opnd_rd    = (phase == PH_OPSRCH) && band_hit && need_read;
  assign m_update   = (phase == PH_INDEX);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_FETCH;
      state  <= '0;
      mc_sel <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH: if (band_hit) begin
          state  <= SW'(1);
          mc_sel <= 1'b1;
          phase  <= PH_COPY;
        end
        PH_COPY: begin
          state <= op_word;
          phase <= want_index ? PH_INDEX : PH_OPSRCH;
        end
        PH_INDEX: begin
          state[BIT_SIGN] <= 1'b0;
          state[BIT_FOUR] <= 1'b0;
          phase           <= PH_OPSRCH;
        end
        PH_OPSRCH: if (band_hit) begin
          state[0] <= 1'b1;
          phase    <= PH_EXEC;
        end
        PH_EXEC: if (done) begin
          state <= '0;
          phase <= PH_FETCH;
          if (take_c) mc_sel <= 1'b0;
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/drum_seq.sv
module drum_seq
  import drum_seq_pkg::*;
#(
  parameter int         DIGITS    = 4,
  parameter int         OP_DIGITS = 2,
  parameter int         BAND_POS  = 2,
  parameter logic [7:0] SKIP_CODE = 8'h26
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          band_valid,
  input  logic [4*DIGITS-1:0]           band_addr,
  input  logic [4*OP_DIGITS+8*DIGITS:0] word_in,
  input  logic [4*DIGITS-1:0]           index_val,
  input  logic                          done,
  input  logic                          take_c,
  output logic [4*OP_DIGITS:0]          state_o,
  output logic [2:0]                    phase_o,
  output logic                          mc_sel_o,
  output logic                          ir_load_o,
  output logic                          opnd_rd_o,
  output logic [4*DIGITS-1:0]           search_addr_o,
  output logic                          ir_sign_o,
  output logic [4*OP_DIGITS-1:0]        ir_op_o,
  output logic [4*DIGITS-1:0]           ir_m_o,
  output logic [4*DIGITS-1:0]           ir_c_o
);
  localparam int AW  = 4 * DIGITS;
  localparam int OPW = 4 * OP_DIGITS;
  localparam int SW  = OPW + 1;
  localparam int WW  = SW + 2 * AW;

  phase_t        phase;
  logic [SW-1:0] state;
  logic          mc_sel, ir_load, opnd_rd, m_update, band_hit, need_read;
  logic          ir_sign;
  logic [OPW-1:0] ir_op;
  logic [AW-1:0] ir_m, ir_c, m_indexed, search_addr;

  assign need_read   = (ir_op != OPW'(SKIP_CODE));
  assign search_addr = (phase == PH_FETCH && !mc_sel) ? ir_c : ir_m;

  drum_addr_match #(.DIGITS(DIGITS)) u_match (
    .valid  (band_valid),
    .band   (band_addr),
    .target (search_addr),
    .hit    (band_hit)
  );

  drum_band_adder #(.DIGITS(DIGITS), .BAND_POS(BAND_POS)) u_adder (
    .addr (ir_m),
    .incr (index_val),
    .sum  (m_indexed)
  );

  drum_seq_ctrl #(.SW(SW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .band_hit  (band_hit),
    .done      (done),
    .take_c    (take_c),
    .need_read (need_read),
    .op_word   ({ir_sign, ir_op}),
    .phase     (phase),
    .state     (state),
    .mc_sel    (mc_sel),
    .ir_load   (ir_load),
    .opnd_rd   (opnd_rd),
    .m_update  (m_update)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sign <= 1'b0;
      ir_op   <= '0;
      ir_m    <= '0;
      ir_c    <= '0;
    end else if (ir_load) begin
      ir_sign <= word_in[WW-1];
      ir_op   <= word_in[2*AW +: OPW];
      ir_m    <= word_in[AW +: AW];
      ir_c    <= word_in[0 +: AW];
    end else if (m_update) begin
      ir_m    <= m_indexed;
    end
  end

  assign state_o       = state;
  assign phase_o       = phase;
  assign mc_sel_o      = mc_sel;
  assign ir_load_o     = ir_load;
  assign opnd_rd_o     = opnd_rd;
  assign search_addr_o = search_addr;
  assign ir_sign_o     = ir_sign;
  assign ir_op_o       = ir_op;
  assign ir_m_o        = ir_m;
  assign ir_c_o        = ir_c;
endmodule

// File: rtl/drum_seq_chk.sv
module drum_seq_chk #(
  parameter int SW = 9,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          band_valid,
  input logic [AW-1:0] band_addr,
  input logic          done,
  input logic [SW-1:0] state_o,
  input logic [2:0]    phase_o,
  input logic          mc_sel_o,
  input logic          ir_load_o,
  input logic          opnd_rd_o,
  input logic [AW-1:0] search_addr_o,
  input logic          ir_sign_o,
  input logic [SW-2:0] ir_op_o,
  input logic [AW-1:0] ir_m_o
);
  a_r3_fetch_sets_one: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd0 && ir_load_o) |=> (state_o == SW'(1) && mc_sel_o && phase_o == 3'd1));

  a_r3_load_on_match: assert property (@(posedge clk) disable iff (rst)
    ir_load_o |-> (band_addr == search_addr_o));

  a_r4_copy_code: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd1) |=> (state_o == {$past(ir_sign_o), $past(ir_op_o)}));

  a_r5_index_clears: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd2) |=> (!state_o[SW-1] && !state_o[2] && phase_o == 3'd3));

  a_r7_read_at_operand: assert property (@(posedge clk) disable iff (rst)
    opnd_rd_o |-> (phase_o == 3'd3 && band_addr == ir_m_o));

  a_r8_gated_by_valid: assert property (@(posedge clk) disable iff (rst)
    !band_valid |-> (!ir_load_o && !opnd_rd_o));

  a_r8_search_holds: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd3 && !band_valid) |=> (phase_o == 3'd3 && $stable(state_o)));

  a_r9_done_returns: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd4 && done) |=> (state_o == '0 && phase_o == 3'd0));
endmodule

bind drum_seq drum_seq_chk #(.SW(SW), .AW(AW)) u_chk (.*);

// File: tb/test_drum_seq.sv
module test_drum_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        band_valid = 1'b0;
  logic [15:0] band_addr = '0;
  logic [40:0] word_in = '0;
  logic [15:0] index_val = '0;
  logic        done = 1'b0;
  logic        take_c = 1'b0;
  logic [8:0]  state_o;
  logic [2:0]  phase_o;
  logic        mc_sel_o, ir_load_o, opnd_rd_o, ir_sign_o;
  logic [15:0] search_addr_o, ir_m_o, ir_c_o;
  logic [7:0]  ir_op_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  drum_seq i_drum_seq (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bcd2int(logic [15:0] b);
    return b[15:12]*1000 + b[11:8]*100 + b[7:4]*10 + b[3:0];
  endfunction

  function automatic logic [15:0] int2bcd(int v);
    return {4'(v/1000), 4'((v/100)%10), 4'((v/10)%10), 4'(v%10)};
  endfunction

  // Banded sum restated on integers: low part mod 200, high part mod 50
  function automatic logic [15:0] model_add(logic [15:0] m, logic [15:0] x);
    int a, b, lo, hi;
    a = bcd2int(m); b = bcd2int(x);
    lo = (a % 200 + b % 200) % 200;
    hi = (a / 200 + b / 200) % 50;
    return int2bcd(hi * 200 + lo);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // Present a matching fetch word and check capture and the code copy
  task automatic do_fetch(logic [15:0] at, logic sg, logic [7:0] op,
                          logic [15:0] m, logic [15:0] c);
    chk("R2 fetch search address", search_addr_o, at);
    band_valid = 1; band_addr = at; word_in = {sg, op, m, c};
    #1 chk("R3 ir_load on match", ir_load_o, 1);
    chk("R7 no operand strobe in fetch", opnd_rd_o, 0);
    step();
    band_valid = 0; word_in = '0;
    chk("R3 state one after match", state_o, 1);
    chk("R3 selector to operand", mc_sel_o, 1);
    chk("R3 captured code", {ir_sign_o, ir_op_o}, {sg, op});
    chk("R3 captured continuation", ir_c_o, c);
    step();
    chk("R4 state holds code", state_o, {sg, op});
    chk("R5 phase after copy", phase_o, (sg || op[2]) ? 2 : 3);
  endtask

  task automatic opnd_match(logic [15:0] at, int rd_exp);
    band_valid = 1; band_addr = at;
    #1 chk("R7 operand strobe", opnd_rd_o, rd_exp);
    chk("R3 no ir_load in operand search", ir_load_o, 0);
    step();
    band_valid = 0;
    chk("R7 phase execute", phase_o, 4);
    chk("R7 state bit 0 set", state_o[0], 1);
  endtask

  task automatic finish_instr(logic tc, int mc_exp, logic [15:0] next_addr);
    done = 1; take_c = tc;
    step();
    done = 0; take_c = 0;
    chk("R9 state cleared", state_o, 0);
    chk("R9 phase fetch", phase_o, 0);
    chk("R9 selector", mc_sel_o, mc_exp);
    chk("R2 next search address", search_addr_o, next_addr);
  endtask

  task automatic t_reset();
    chk("R1 state", state_o, 0);
    chk("R1 phase", phase_o, 0);
    chk("R1 selector", mc_sel_o, 0);
    chk("R1 ir_load", ir_load_o, 0);
    chk("R1 opnd_rd", opnd_rd_o, 0);
    chk("R1 search address", search_addr_o, 0);
  endtask

  task automatic t_indexed_read();
    // mismatch and invalid word-times leave fetch waiting
    band_valid = 1; band_addr = 16'h0005;
    #1 chk("R8 mismatch no load", ir_load_o, 0);
    step();
    band_valid = 0; band_addr = 16'h0000;
    #1 chk("R8 invalid no load", ir_load_o, 0);
    step();
    chk("R8 still fetch", phase_o, 0);
    index_val = 16'h0195;
    do_fetch(16'h0000, 1'b0, 8'h24, 16'h0123, 16'h0456);
    step();
    chk("R6 indexed by 0195", ir_m_o, 16'h0118);
    chk("R5 bits cleared", state_o, 9'h020);
    chk("R5 phase operand search", phase_o, 3);
    // done during operand search is ignored
    done = 1; band_valid = 1; band_addr = 16'h0117;
    #1 chk("R8 mismatch no read", opnd_rd_o, 0);
    step();
    done = 0; band_valid = 0;
    chk("R10 done ignored phase", phase_o, 3);
    chk("R10 done ignored state", state_o, 9'h020);
    opnd_match(16'h0118, 1);
    chk("R7 state after match", state_o, 9'h021);
    finish_instr(1'b0, 1, 16'h0118);
  endtask

  task automatic t_no_index();
    do_fetch(16'h0118, 1'b0, 8'h11, 16'h0777, 16'h0300);
    chk("R5 no index keeps M", ir_m_o, 16'h0777);
    opnd_match(16'h0777, 1);
    finish_instr(1'b1, 0, 16'h0300);
  endtask

  task automatic t_skip_read();
    do_fetch(16'h0300, 1'b0, 8'h26, 16'h0050, 16'h0000);
    step();
    chk("R6 0050 minus 5", ir_m_o, 16'h0045);
    chk("R5 state after index", state_o, 9'h022);
    opnd_match(16'h0045, 0);
    chk("R7 skip code state", state_o, 9'h023);
    finish_instr(1'b1, 0, 16'h0000);
  endtask

  task automatic t_adder_vectors();
    logic [15:0] mv [0:3];
    logic [15:0] xv [0:3];
    logic [31:0] seed;
    logic [15:0] m, x, e;
    mv[0] = 16'h9999; xv[0] = 16'h0001;
    mv[1] = 16'h0003; xv[1] = 16'h0195;
    mv[2] = 16'h0199; xv[2] = 16'h0001;
    mv[3] = 16'h4567; xv[3] = 16'h5432;
    seed = 32'h1234_5678;
    for (int k = 0; k < 20; k++) begin
      if (k < 4) begin
        m = mv[k]; x = xv[k];
      end else begin
        for (int d = 0; d < 4; d++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          m[4*d +: 4] = 4'((seed >> 16) % 10);
          x[4*d +: 4] = 4'((seed >> 8) % 10);
        end
      end
      e = model_add(m, x);
      index_val = x;
      do_fetch(16'h0000, 1'b1, 8'h00, m, 16'h0000);
      step();
      chk("R6 banded sum", ir_m_o, e);
      chk("R5 sign cleared", state_o, 0);
      opnd_match(e, 1);
      finish_instr(1'b1, 0, 16'h0000);
    end
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_indexed_read();
    t_no_index();
    t_skip_read();
    t_adder_vectors();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule